// File: doc/BRIEF.md
# Buck Regulator Protection Sequencer

This block sits between the protection comparators of a synchronous buck controller and its gate drivers. It watches digital flags for supply undervoltage, output overvoltage, output undervoltage, per-cycle overcurrent and over-temperature. It also takes the enable input, a soft-start-done flag, a reference-move mask and a switching-cycle tick. From these it decides whether the high-side and low-side switches may run, whether the low side is forced on, and whether the output discharge path and the soft-start reset are active. It also reports a fault code.

Each fault class follows its own path:
- Overvoltage and undervoltage must persist for a programmable number of clock cycles before they count.
- Overcurrent trims the high-side pulse in every switching cycle where it appears. It latches only after a programmable run of consecutive bad cycles.
- Overvoltage pulls the output down through the low side until feedback has fallen below the undervoltage threshold.
- Latched faults stay set until enable goes low or the supply drops out.
- Supply dropout and over-temperature are not latched. The block restarts with a fresh soft-start once they clear.

States:
- `ST_OFF`: disabled, or supply low.
- `ST_SOFTSTART`: switching, with the reference ramping.
- `ST_RUN`: regulating.
- `ST_OV_HOLD`: overvoltage latched.
- `ST_LATCHED`: undervoltage or overcurrent latched.
- `ST_THERMAL`: over-temperature pause.

Transitions:
- `ST_OFF`→`ST_SOFTSTART` on enable with the supply good.
- `ST_SOFTSTART`→`ST_RUN` on soft-start done.
- `ST_SOFTSTART`/`ST_RUN`→`ST_THERMAL` on over-temperature.
- `ST_SOFTSTART`/`ST_RUN`→`ST_OV_HOLD` on an overvoltage trip.
- `ST_SOFTSTART`/`ST_RUN`→`ST_LATCHED` on an undervoltage or overcurrent trip.
- `ST_THERMAL`→`ST_SOFTSTART` when the temperature flag clears.
- Any state →`ST_OFF` on enable low or supply low. This transition has top priority.

Top module: `buck_guard_seq`

## Requirements
- R1: While `rst_n` is low, enable is low or supply-low is high, the block is off: `hs_en_o`=0, `ls_en_o`=0, `ls_force_o`=0, `dschg_o`=1, `ss_rst_o`=1, `fault_code_o`=0. One clock edge after enable is sampled high with the supply good, the block switches: `hs_en_o`=1, `ls_en_o`=1, `dschg_o`=0, `ss_rst_o`=0.
- R2: Overvoltage sampled high on OV_BLANK consecutive edges, while switching and with no reference move, latches the overvoltage fault with code 1. A shorter burst changes nothing.
- R3: In the overvoltage fault the high side is off, the low side is forced on (`ls_en_o`=1, `ls_force_o`=1) and discharge is on. One edge after undervoltage is sampled high, the low side is released (`ls_en_o`=0, `ls_force_o`=0), and code 1 stays.
- R4: Undervoltage is ignored until soft-start done has moved the block to `ST_RUN`. After that, undervoltage sampled on UV_BLANK consecutive edges latches code 2 with both drives off. A shorter burst changes nothing.
- R5: While the reference-move flag is high, neither overvoltage nor undervoltage advances toward a fault, however long they last.
- R6: Overcurrent drops `hs_en_o` in the cycle it is seen. `hs_en_o` stays low until the next cycle tick has passed with overcurrent gone, while the low side keeps switching.
- R7: Overcurrent present in OC_CYCLES consecutive switching cycles (counted at the ticks) latches code 3 with both drives off. A tick period free of overcurrent restarts the count.
- R8: A latched fault (code 1, 2 or 3) is left only by enable low or supply-low high. Over-temperature and comparator flags do not change its outputs.
- R9: Supply-low high forces the off state one edge later with code 0. When the flag clears with enable high, switching restarts one edge later with no fault recorded.
- R10: Over-temperature while switching stops both drives, asserts the soft-start reset and discharge, and shows code 4. One edge after the flag clears, the block switches again in soft-start with code 0.
- R11: The discharge output is high in every fault state and while off, and low while switching.
- R12: The fault code records the first fault that latched. Faults arriving later leave it unchanged until the latch is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en_i | input | 1 | Regulator enable |
| supply_low_i | input | 1 | Supply undervoltage lockout flag |
| ov_i | input | 1 | Feedback above overvoltage threshold |
| uv_i | input | 1 | Feedback below undervoltage threshold |
| oc_i | input | 1 | Inductor current above limit |
| hot_i | input | 1 | Over-temperature flag |
| ss_done_i | input | 1 | Soft-start ramp complete |
| ref_move_i | input | 1 | Reference transition in progress |
| tick_i | input | 1 | One-cycle pulse at each switching-cycle start |
| hs_en_o | output | 1 | High-side switch may conduct |
| ls_en_o | output | 1 | Low-side switch may conduct |
| ls_force_o | output | 1 | Low-side switch forced fully on |
| dschg_o | output | 1 | Output discharge path on |
| ss_rst_o | output | 1 | Hold reference and soft-start in reset |
| fault_code_o | output | 3 | 0 none, 1 overvoltage, 2 undervoltage, 3 overcurrent, 4 over-temperature |

## Verification
The bench builds the block with OV_BLANK=6, UV_BLANK=10 and OC_CYCLES=3 instead of the microsecond-scale defaults of 300, 660 and 8. At these values each persistence window can be hit exactly, and missed by one edge, within a few dozen cycles. The consecutive-cycle overcurrent count, including its reset on a clean cycle, fits in a handful of tick pulses. Every exit rule can then be exercised back to back in one short run: latched, auto-restart and lockout.

// File: rtl/buck_guard_pkg.sv
package buck_guard_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_SOFTSTART = 3'd1,
        ST_RUN       = 3'd2,
        ST_OV_HOLD   = 3'd3,
        ST_LATCHED   = 3'd4,
        ST_THERMAL   = 3'd5
    } guard_state_t;

    typedef enum logic [2:0] {
        FC_NONE    = 3'd0,
        FC_OVER    = 3'd1,
        FC_UNDER   = 3'd2,
        FC_CURRENT = 3'd3,
        FC_THERMAL = 3'd4
    } fault_code_t;

    typedef struct packed {
        logic hs_en;
        logic ls_en;
        logic ls_force;
        logic dschg;
        logic ss_rst;
    } drive_cmd_t;

endpackage

// File: rtl/bg_persist.sv
// Counts consecutive qualified samples; trips on the HOLD-th one.
module bg_persist #(
    parameter int HOLD = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic qual_i,
    output logic trip_o
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic [CW-1:0] cnt_q;
    logic          at_last;

    assign at_last = (cnt_q == LAST);
    assign trip_o  = qual_i && at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!qual_i) begin
            cnt_q <= '0;
        end else if (!at_last) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/bg_oc_window.sv
// Per-switching-cycle overcurrent flag and consecutive bad-cycle counter.
module bg_oc_window #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed_i,
    input  logic oc_i,
    input  logic tick_i,
    output logic cut_o,
    output logic trip_o
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic          seen_q;
    logic [CW-1:0] run_q;
    logic          hit;
    logic          at_last;

    assign hit     = seen_q || oc_i;
    assign at_last = (run_q == LAST);
    assign cut_o   = armed_i && hit;
    assign trip_o  = armed_i && tick_i && hit && at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            run_q  <= '0;
        end else if (!armed_i) begin
            seen_q <= 1'b0;
            run_q  <= '0;
        end else if (tick_i) begin
            seen_q <= 1'b0;
            if (!hit) begin
                run_q <= '0;
            end else if (!at_last) begin
                run_q <= run_q + CW'(1);
            end
        end else if (oc_i) begin
            seen_q <= 1'b1;
        end
    end
endmodule

// File: rtl/bg_drive_decode.sv
// Maps the sequencer state to gate and housekeeping commands.
module bg_drive_decode
    import buck_guard_pkg::*;
(
    input  guard_state_t state_i,
    input  logic         oc_cut_i,
    input  logic         released_i,
    output drive_cmd_t   cmd_o
);
    always_comb begin
        cmd_o = '{hs_en: 1'b0, ls_en: 1'b0, ls_force: 1'b0,
                  dschg: 1'b1, ss_rst: 1'b1};
        unique case (state_i)
            ST_SOFTSTART, ST_RUN: begin
                cmd_o.hs_en  = !oc_cut_i;
                cmd_o.ls_en  = 1'b1;
                cmd_o.dschg  = 1'b0;
                cmd_o.ss_rst = 1'b0;
            end
            ST_OV_HOLD: begin
                cmd_o.ls_en    = !released_i;
                cmd_o.ls_force = !released_i;
            end
            ST_OFF, ST_LATCHED, ST_THERMAL: begin
                cmd_o.hs_en = 1'b0;
            end
            default: begin
                cmd_o.hs_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/buck_guard_seq.sv
module buck_guard_seq
    import buck_guard_pkg::*;
#(
    parameter int OV_BLANK  = 300,
    parameter int UV_BLANK  = 660,
    parameter int OC_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       supply_low_i,
    input  logic       ov_i,
    input  logic       uv_i,
    input  logic       oc_i,
    input  logic       hot_i,
    input  logic       ss_done_i,
    input  logic       ref_move_i,
    input  logic       tick_i,
    output logic       hs_en_o,
    output logic       ls_en_o,
    output logic       ls_force_o,
    output logic       dschg_o,
    output logic       ss_rst_o,
    output logic [2:0] fault_code_o
);
    guard_state_t state_q, state_d;
    fault_code_t  code_q, code_d;
    logic         released_q;
    logic         active;
    logic         ov_qual, uv_qual;
    logic         ov_trip, uv_trip, oc_trip, oc_cut;
    logic         go_off;
    drive_cmd_t   cmd;

    assign active  = (state_q == ST_SOFTSTART) || (state_q == ST_RUN);
    assign go_off  = !en_i || supply_low_i;
    assign ov_qual = active && ov_i && !ref_move_i;
    assign uv_qual = (state_q == ST_RUN) && uv_i && !ref_move_i;

    bg_persist #(.HOLD(OV_BLANK)) u_ov_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .qual_i (ov_qual),
        .trip_o (ov_trip)
    );

    bg_persist #(.HOLD(UV_BLANK)) u_uv_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .qual_i (uv_qual),
        .trip_o (uv_trip)
    );

    bg_oc_window #(.CYCLES(OC_CYCLES)) u_oc (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed_i (active),
        .oc_i    (oc_i),
        .tick_i  (tick_i),
        .cut_o   (oc_cut),
        .trip_o  (oc_trip)
    );

    // Next state and fault record
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            ST_OFF: begin
                code_d = FC_NONE;
                if (!go_off) state_d = ST_SOFTSTART;
            end
            ST_SOFTSTART, ST_RUN: begin
                if (go_off) begin
                    state_d = ST_OFF;
                    code_d  = FC_NONE;
                end else if (hot_i) begin
                    state_d = ST_THERMAL;
                    code_d  = FC_THERMAL;
                end else if (ov_trip) begin
                    state_d = ST_OV_HOLD;
                    code_d  = FC_OVER;
                end else if (uv_trip) begin
                    state_d = ST_LATCHED;
                    code_d  = FC_UNDER;
                end else if (oc_trip) begin
                    state_d = ST_LATCHED;
                    code_d  = FC_CURRENT;
                end else if (state_q == ST_SOFTSTART && ss_done_i) begin
                    state_d = ST_RUN;
                end
            end
            ST_OV_HOLD, ST_LATCHED: begin
                if (go_off) begin
                    state_d = ST_OFF;
                    code_d  = FC_NONE;
                end
            end
            ST_THERMAL: begin
                if (go_off) begin
                    state_d = ST_OFF;
                    code_d  = FC_NONE;
                end else if (!hot_i) begin
                    state_d = ST_SOFTSTART;
                    code_d  = FC_NONE;
                end
            end
            default: begin
                state_d = ST_OFF;
                code_d  = FC_NONE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_OFF;
            code_q     <= FC_NONE;
            released_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            code_q     <= code_d;
            if (state_q != ST_OV_HOLD) begin
                released_q <= 1'b0;
            end else if (uv_i) begin
                released_q <= 1'b1;
            end
        end
    end

    // Outputs
    bg_drive_decode u_dec (
        .state_i    (state_q),
        .oc_cut_i   (oc_cut),
        .released_i (released_q),
        .cmd_o      (cmd)
    );

    always_comb begin
        hs_en_o      = cmd.hs_en;
        ls_en_o      = cmd.ls_en;
        ls_force_o   = cmd.ls_force;
        dschg_o      = cmd.dschg;
        ss_rst_o     = cmd.ss_rst;
        fault_code_o = code_q;
    end
endmodule

// File: rtl/buck_guard_seq_chk.sv
module buck_guard_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic       supply_low_i,
    input logic       uv_i,
    input logic       hot_i,
    input logic       hs_en_o,
    input logic       ls_en_o,
    input logic       ls_force_o,
    input logic       dschg_o,
    input logic [2:0] fault_code_o
);
    logic latched;
    assign latched = (fault_code_o >= 3'd1) && (fault_code_o <= 3'd3);

    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (dschg_o && !hs_en_o && !ls_en_o && fault_code_o == 3'd0)); // R1

    AST_FORCE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ls_force_o |-> (!hs_en_o && ls_en_o && fault_code_o == 3'd1)); // R3

    AST_OV_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_force_o && uv_i) |=> !ls_force_o); // R3

    AST_LATCH_NO_HIGH_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        latched |-> (!hs_en_o && dschg_o)); // R8

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && en_i && !supply_low_i) |=> $stable(fault_code_o)); // R12

    AST_UVLO_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low_i |=> (fault_code_o == 3'd0 && !hs_en_o)); // R9

    AST_HOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_i && hs_en_o && en_i && !supply_low_i) |=> (!hs_en_o && !ls_en_o && fault_code_o == 3'd4)); // R10

    AST_DISCHARGE_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en_o |-> !dschg_o); // R11
endmodule

bind buck_guard_seq buck_guard_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .supply_low_i (supply_low_i),
    .uv_i         (uv_i),
    .hot_i        (hot_i),
    .hs_en_o      (hs_en_o),
    .ls_en_o      (ls_en_o),
    .ls_force_o   (ls_force_o),
    .dschg_o      (dschg_o),
    .fault_code_o (fault_code_o)
);

// File: tb/buck_guard_seq_test.sv
module buck_guard_seq_test;
    localparam int OVB = 6;
    localparam int UVB = 10;
    localparam int OCC = 3;

    // {hs, ls, force, dschg, ssrst, code[2:0]}
    localparam logic [7:0] E_OFF    = 8'b0001_1000;
    localparam logic [7:0] E_ACT    = 8'b1100_0000;
    localparam logic [7:0] E_CUT    = 8'b0100_0000;
    localparam logic [7:0] E_OVPULL = 8'b0111_1001;
    localparam logic [7:0] E_OVREL  = 8'b0001_1001;
    localparam logic [7:0] E_UVLAT  = 8'b0001_1010;
    localparam logic [7:0] E_OCLAT  = 8'b0001_1011;
    localparam logic [7:0] E_HOT    = 8'b0001_1100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_i = 1'b0, supply_low_i = 1'b0, ov_i = 1'b0, uv_i = 1'b0;
    logic oc_i = 1'b0, hot_i = 1'b0, ss_done_i = 1'b0, ref_move_i = 1'b0, tick_i = 1'b0;
    logic hs_en_o, ls_en_o, ls_force_o, dschg_o, ss_rst_o;
    logic [2:0] fault_code_o;

    always #2.5 clk = ~clk;

    buck_guard_seq #(.OV_BLANK(OVB), .UV_BLANK(UVB), .OC_CYCLES(OCC)) uut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .supply_low_i(supply_low_i),
        .ov_i(ov_i), .uv_i(uv_i), .oc_i(oc_i), .hot_i(hot_i),
        .ss_done_i(ss_done_i), .ref_move_i(ref_move_i), .tick_i(tick_i),
        .hs_en_o(hs_en_o), .ls_en_o(ls_en_o), .ls_force_o(ls_force_o),
        .dschg_o(dschg_o), .ss_rst_o(ss_rst_o), .fault_code_o(fault_code_o)
    );

    typedef struct {
        string      req;
        string      tag;
        logic [7:0] exp;
    } item_t;

    item_t q[$];
    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    event  chk_ev;

    // Monitor: pops expected items and compares against outputs
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] got;
                it  = q.pop_front();
                got = {hs_en_o, ls_en_o, ls_force_o, dschg_o, ss_rst_o, fault_code_o};
                n_run++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s %s: got %b expected %b", it.req, it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string req, input string tag, input logic [7:0] exp);
        item_t it;
        it.req = req; it.tag = tag; it.exp = exp;
        q.push_back(it);
        ->chk_ev;
        #0.1;
    endtask

    task automatic tick_pulse();
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
    endtask

    task automatic restart_run();
        en_i = 1'b0; step(1);
        en_i = 1'b1; ss_done_i = 1'b1; step(2);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        step(2);
        expect_out("R1", "reset state", E_OFF);
        rst_n = 1'b1; step(2);
        expect_out("R1", "disabled after reset", E_OFF);
        en_i = 1'b1; step(1);
        expect_out("R1", "switching one edge after enable", E_ACT);

        // R4: undervoltage ignored during soft-start
        uv_i = 1'b1; step(UVB + 5);
        expect_out("R4", "uv ignored in soft-start", E_ACT);
        uv_i = 1'b0; ss_done_i = 1'b1; step(2);

        // R2: short overvoltage burst
        ov_i = 1'b1; step(OVB - 1);
        ov_i = 1'b0; step(1);
        expect_out("R2", "ov one edge short", E_ACT);
        // R5: reference move masks ov
        ref_move_i = 1'b1; ov_i = 1'b1; step(OVB * 3);
        expect_out("R5", "ov masked by ref move", E_ACT);
        ov_i = 1'b0; ref_move_i = 1'b0; step(1);
        // R2: full burst
        ov_i = 1'b1; step(OVB - 1);
        expect_out("R2", "ov before window ends", E_ACT);
        step(1);
        expect_out("R3", "ov latched, low side forced", E_OVPULL);
        ov_i = 1'b0; step(3);
        expect_out("R3", "low side held until uv", E_OVPULL);
        uv_i = 1'b1; step(1);
        expect_out("R3", "low side released by uv", E_OVREL);
        step(UVB + 3);
        expect_out("R12", "uv does not overwrite code 1", E_OVREL);
        uv_i = 1'b0; hot_i = 1'b1; oc_i = 1'b1; step(4);
        expect_out("R8", "latch ignores hot and oc", E_OVREL);
        hot_i = 1'b0; oc_i = 1'b0;
        en_i = 1'b0; step(1);
        expect_out("R8", "enable low clears latch", E_OFF);
        en_i = 1'b1; step(2);
        expect_out("R1", "restart after toggle", E_ACT);

        // R5 / R4: undervoltage in run
        ref_move_i = 1'b1; uv_i = 1'b1; step(UVB * 2);
        expect_out("R5", "uv masked by ref move", E_ACT);
        ref_move_i = 1'b0; uv_i = 1'b0; step(1);
        uv_i = 1'b1; step(UVB - 1);
        uv_i = 1'b0; step(1);
        expect_out("R4", "uv one edge short", E_ACT);
        uv_i = 1'b1; step(UVB);
        expect_out("R4", "uv latched", E_UVLAT);
        uv_i = 1'b0; ov_i = 1'b1; step(OVB + 2);
        expect_out("R12", "ov after uv keeps code 2", E_UVLAT);
        ov_i = 1'b0;
        restart_run();
        expect_out("R8", "uv latch cleared by enable", E_ACT);

        // R6 / R7: overcurrent
        oc_i = 1'b1; step(1);
        expect_out("R6", "oc cuts high side", E_CUT);
        oc_i = 1'b0; step(2);
        expect_out("R6", "cut held until tick", E_CUT);
        tick_pulse();
        expect_out("R6", "high side back after tick", E_ACT);
        tick_pulse();   // clean cycle resets count
        oc_i = 1'b1;
        tick_pulse();
        tick_pulse();
        expect_out("R7", "count after clean cycle not yet at limit", E_CUT);
        tick_pulse();
        expect_out("R7", "oc latched", E_OCLAT);
        oc_i = 1'b0;

        // R9: supply lockout clears and restarts
        supply_low_i = 1'b1; step(1);
        expect_out("R9", "supply low forces off", E_OFF);
        supply_low_i = 1'b0; step(1);
        expect_out("R9", "restart without fault", E_ACT);
        step(2);
        supply_low_i = 1'b1; step(1);
        expect_out("R11", "discharge on when supply low", E_OFF);
        supply_low_i = 1'b0; step(2);

        // R10: thermal auto-restart
        ss_done_i = 1'b0; hot_i = 1'b1; step(1);
        expect_out("R10", "hot stops drives", E_HOT);
        step(5);
        expect_out("R10", "hot holds", E_HOT);
        hot_i = 1'b0; step(1);
        expect_out("R10", "restart after hot clears", E_ACT);
        uv_i = 1'b1; step(UVB + 2);
        expect_out("R4", "uv ignored after thermal restart", E_ACT);
        uv_i = 1'b0; step(1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule